// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home-side controller that keeps caches coherent in a shared-memory multiprocessor whose nodes talk only through point-to-point messages. For every memory block it owns, it keeps a small directory entry: whether the block is uncached, held read-only by a set of nodes, or held writable by a single node. A cache miss reaches it as a request message naming the requesting node, the block and whether write permission is wanted.

On each request the controller works out which protocol action the directory entry calls for. That action may be nothing, invalidations to other holders, or a fetch of the dirty copy from the current owner. Each action goes out as a separate message to one node, because the fabric has no broadcast. The controller counts the acknowledgements that come back. It sends the grant to the requester only when none are outstanding, and it updates the directory entry at that point.

The controller handles one transaction at a time. Any request that arrives while a transaction is open is refused at once with a retry notice, and the directory is left untouched.

Top module: `dirc_ctrl`

## Requirements
- R1: After reset every block is uncached and rsp_valid, msg_valid and rty_valid are low.
- R2: A read request to an uncached or shared block gets a grant with rsp_excl=0 in the cycle after it is accepted. No message is sent, and the requester joins the sharer set.
- R3: A write request to an uncached block gets a grant with rsp_excl=1 in the cycle after it is accepted, and no message is sent.
- R4: A write request to a shared block sends one invalidate (msg_fetch=0) to every sharer except the requester. These go one per cycle in ascending node number, starting in the cycle after acceptance, and none goes to the requester.
- R5: The grant is withheld while any message is unsent or unacknowledged. It appears in the second cycle after the cycle in which the last ack_valid is presented.
- R6: A read request to a block held exclusively by another node sends a single fetch (msg_fetch=1) to the owner. After its acknowledgement, the old owner and the requester are both sharers, and the grant has rsp_excl=0.
- R7: A write request to a block held exclusively by another node sends one invalidate to the owner. After its acknowledgement the requester becomes the only owner, with rsp_excl=1.
- R8: A request of either kind from the current exclusive owner is granted with rsp_excl=1 in the next cycle, with no message and no change to the entry.
- R9: A request presented while a transaction is open (messages pending or grant cycle) is refused. In the next cycle rty_valid is high, with rty_node and rty_blk naming it, and the directory is not changed by it.
- R10: A write request from a node that is the only sharer is granted exclusive in the next cycle with no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request present this cycle |
| req_write | input | 1 | 1 = write permission wanted, 0 = read |
| req_node | input | NW | Requesting node |
| req_blk | input | AW | Requested block |
| rsp_valid | output | 1 | Grant to the requester |
| rsp_excl | output | 1 | 1 = exclusive grant, 0 = shared grant |
| rsp_node | output | NW | Node receiving the grant |
| rsp_blk | output | AW | Block granted |
| msg_valid | output | 1 | Protocol message to one node |
| msg_fetch | output | 1 | 1 = fetch from owner, 0 = invalidate |
| msg_node | output | NW | Destination node of the message |
| msg_blk | output | AW | Block the message concerns |
| ack_valid | input | 1 | One acknowledgement for an outstanding message |
| rty_valid | output | 1 | Refused request, retry later |
| rty_node | output | NW | Node whose request was refused |
| rty_blk | output | AW | Block of the refused request |

## Verification
The hardest case to reach is a request that arrives in the middle of an open transaction. The controller must refuse it while it still has an invalidate on the wire and an acknowledgement owed. The refusal must also leave no trace in the directory. The stimulus first builds a block held by one owner, then starts a write from another node, and injects a read to a different, uncached block in the cycle the invalidate is visible. It then checks the retry notice, completes the open transaction, and writes the refused block from a third node. That write must be granted with no messages, which shows the refused node never became a sharer.

// File: rtl/dirc_pkg.sv
package dirc_pkg;

  typedef enum logic [1:0] {
    BLK_NONE = 2'd0,
    BLK_SHR  = 2'd1,
    BLK_EXC  = 2'd2
  } blk_st_e;

  typedef enum logic [1:0] {
    CT_IDLE  = 2'd0,
    CT_WAIT  = 2'd1,
    CT_REPLY = 2'd2
  } ctl_st_e;

  localparam logic MK_INV   = 1'b0;
  localparam logic MK_FETCH = 1'b1;

endpackage

// File: rtl/dirc_store.sv
module dirc_store
  import dirc_pkg::*;
#(
  parameter int NN = 4,
  parameter int NB = 8,
  localparam int AW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_blk,
  output blk_st_e       rd_st,
  output logic [NN-1:0] rd_vec,
  input  logic          we,
  input  logic [AW-1:0] wr_blk,
  input  blk_st_e       wr_st,
  input  logic [NN-1:0] wr_vec
);

  blk_st_e       st_q  [NB];
  logic [NN-1:0] vec_q [NB];

  for (genvar b = 0; b < NB; b++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (wr_blk == AW'(b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[b]  <= BLK_NONE;
        vec_q[b] <= '0;
      end else if (ent_en) begin
        st_q[b]  <= wr_st;
        vec_q[b] <= wr_vec;
      end
    end
  end

  assign rd_st  = st_q[rd_blk];
  assign rd_vec = vec_q[rd_blk];

  // R7
  excl_single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wr_st == BLK_EXC) |-> ($countones(wr_vec) == 1));

  // R2
  shared_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wr_st == BLK_SHR) |-> (wr_vec != '0));

endmodule

// File: rtl/dirc_seq.sv
module dirc_seq #(
  parameter int NN = 4,
  localparam int NW = (NN > 1) ? $clog2(NN) : 1,
  localparam int CW = $clog2(NN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NN-1:0] mask,
  input  logic          kind,
  input  logic          ack_valid,
  output logic          msg_valid,
  output logic          msg_kind,
  output logic [NW-1:0] msg_node,
  output logic          done
);

  logic [NN-1:0] pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          kind_q, kind_d;
  logic [NW-1:0] low;
  logic          send, take, en;

  always_comb begin
    low = '0;
    for (int i = NN - 1; i >= 0; i--) begin
      if (pend_q[i]) low = NW'(i);
    end
  end

  assign send = act_q && (pend_q != '0);
  assign take = act_q && ack_valid && (cnt_q != '0);
  assign done = act_q && (pend_q == '0) && (cnt_q == '0);
  assign en   = start || act_q;

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    kind_d = kind_q;
    if (start) begin
      pend_d = mask;
      cnt_d  = '0;
      act_d  = 1'b1;
      kind_d = kind;
    end else begin
      if (send) pend_d[low] = 1'b0;
      cnt_d = cnt_q + CW'(send) - CW'(take);
      if (done) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      kind_q <= 1'b0;
    end else if (en) begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      kind_q <= kind_d;
    end
  end

  assign msg_valid = send;
  assign msg_kind  = kind_q;
  assign msg_node  = low;

  // R4
  one_msg_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));

  // R4
  msg_to_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> !pend_q[$past(msg_node)]);

endmodule

// File: rtl/dirc_ctrl.sv
module dirc_ctrl
  import dirc_pkg::*;
#(
  parameter int NN = 4,
  parameter int NB = 8,
  localparam int NW = (NN > 1) ? $clog2(NN) : 1,
  localparam int AW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [NW-1:0] req_node,
  input  logic [AW-1:0] req_blk,
  output logic          rsp_valid,
  output logic          rsp_excl,
  output logic [NW-1:0] rsp_node,
  output logic [AW-1:0] rsp_blk,
  output logic          msg_valid,
  output logic          msg_fetch,
  output logic [NW-1:0] msg_node,
  output logic [AW-1:0] msg_blk,
  input  logic          ack_valid,
  output logic          rty_valid,
  output logic [NW-1:0] rty_node,
  output logic [AW-1:0] rty_blk
);

  ctl_st_e       ctl_q, ctl_d;
  logic [NW-1:0] node_q;
  logic [AW-1:0] blk_q;
  logic          excl_q;
  blk_st_e       nst_q;
  logic [NN-1:0] nvec_q;

  blk_st_e       rd_st;
  logic [NN-1:0] rd_vec;
  logic [NN-1:0] req_bit;

  blk_st_e       nst_c;
  logic [NN-1:0] nvec_c;
  logic [NN-1:0] mask_c;
  logic          kind_c;
  logic          excl_c;

  logic          accept, seq_start, seq_done;
  logic          rty_q;
  logic [NW-1:0] rty_node_q;
  logic [AW-1:0] rty_blk_q;

  dirc_store #(.NN(NN), .NB(NB)) i_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_blk (req_blk),
    .rd_st  (rd_st),
    .rd_vec (rd_vec),
    .we     (ctl_q == CT_REPLY),
    .wr_blk (blk_q),
    .wr_st  (nst_q),
    .wr_vec (nvec_q)
  );

  assign accept    = req_valid && (ctl_q == CT_IDLE);
  assign req_bit   = NN'(1) << req_node;
  assign seq_start = accept && (mask_c != '0);

  always_comb begin
    nst_c  = rd_st;
    nvec_c = rd_vec;
    mask_c = '0;
    kind_c = MK_INV;
    excl_c = req_write;
    unique case (rd_st)
      BLK_SHR: begin
        if (req_write) begin
          nst_c  = BLK_EXC;
          nvec_c = req_bit;
          mask_c = rd_vec & ~req_bit;
        end else begin
          nvec_c = rd_vec | req_bit;
        end
      end
      BLK_EXC: begin
        if (rd_vec == req_bit) begin
          excl_c = 1'b1;
        end else if (req_write) begin
          nvec_c = req_bit;
          mask_c = rd_vec;
        end else begin
          nst_c  = BLK_SHR;
          nvec_c = rd_vec | req_bit;
          mask_c = rd_vec;
          kind_c = MK_FETCH;
        end
      end
      default: begin
        nst_c  = req_write ? BLK_EXC : BLK_SHR;
        nvec_c = req_bit;
      end
    endcase
  end

  dirc_seq #(.NN(NN)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (seq_start),
    .mask      (mask_c),
    .kind      (kind_c),
    .ack_valid (ack_valid),
    .msg_valid (msg_valid),
    .msg_kind  (msg_fetch),
    .msg_node  (msg_node),
    .done      (seq_done)
  );

  always_comb begin
    ctl_d = ctl_q;
    unique case (ctl_q)
      CT_IDLE:  if (accept) ctl_d = seq_start ? CT_WAIT : CT_REPLY;
      CT_WAIT:  if (seq_done) ctl_d = CT_REPLY;
      default:  ctl_d = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CT_IDLE;
    else        ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      node_q <= '0;
      blk_q  <= '0;
      excl_q <= 1'b0;
      nst_q  <= BLK_NONE;
      nvec_q <= '0;
    end else if (accept) begin
      node_q <= req_node;
      blk_q  <= req_blk;
      excl_q <= excl_c;
      nst_q  <= nst_c;
      nvec_q <= nvec_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rty_q      <= 1'b0;
      rty_node_q <= '0;
      rty_blk_q  <= '0;
    end else begin
      rty_q <= req_valid && (ctl_q != CT_IDLE);
      if (req_valid) begin
        rty_node_q <= req_node;
        rty_blk_q  <= req_blk;
      end
    end
  end

  assign rsp_valid = (ctl_q == CT_REPLY);
  assign rsp_excl  = excl_q;
  assign rsp_node  = node_q;
  assign rsp_blk   = blk_q;
  assign msg_blk   = blk_q;
  assign rty_valid = rty_q;
  assign rty_node  = rty_node_q;
  assign rty_blk   = rty_blk_q;

  // R9
  retry_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rty_valid |-> ($past(req_valid) && $past(ctl_q) != CT_IDLE));

  // R2
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5
  no_grant_with_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !rsp_valid);

  // R5
  grant_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(ctl_q) == CT_WAIT) |-> !$past(msg_valid));

endmodule

// File: tb/test_dirc_ctrl.sv
module test_dirc_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [1:0] req_node = '0;
  logic [2:0] req_blk = '0;
  logic       ack_valid = 1'b0;
  logic       rsp_valid, rsp_excl, msg_valid, msg_fetch, rty_valid;
  logic [1:0] rsp_node, msg_node, rty_node;
  logic [2:0] rsp_blk, msg_blk, rty_blk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dirc_ctrl #(.NN(4), .NB(8)) i_dirc_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_node(req_node), .req_blk(req_blk),
    .rsp_valid(rsp_valid), .rsp_excl(rsp_excl), .rsp_node(rsp_node), .rsp_blk(rsp_blk),
    .msg_valid(msg_valid), .msg_fetch(msg_fetch), .msg_node(msg_node), .msg_blk(msg_blk),
    .ack_valid(ack_valid),
    .rty_valid(rty_valid), .rty_node(rty_node), .rty_blk(rty_blk)
  );

  // fields: {write, node[1:0], blk[2:0], inval/fetch mask[3:0], fetch, excl, req tag[3:0]}
  localparam logic [15:0] TBL [13] = '{
    {1'b0, 2'd0, 3'd0, 4'b0000, 1'b0, 1'b0, 4'd2},  // R2 read, uncached
    {1'b0, 2'd1, 3'd0, 4'b0000, 1'b0, 1'b0, 4'd2},  // R2 read, shared
    {1'b0, 2'd2, 3'd0, 4'b0000, 1'b0, 1'b0, 4'd2},  // R2 read, shared
    {1'b1, 2'd1, 3'd0, 4'b0101, 1'b0, 1'b1, 4'd4},  // R4 write, sharers 0,1,2
    {1'b0, 2'd3, 3'd0, 4'b0010, 1'b1, 1'b0, 4'd6},  // R6 read, owner 1
    {1'b1, 2'd2, 3'd0, 4'b1010, 1'b0, 1'b1, 4'd6},  // R6 sharers now 1 and 3
    {1'b1, 2'd0, 3'd0, 4'b0100, 1'b0, 1'b1, 4'd7},  // R7 write, owner 2
    {1'b0, 2'd0, 3'd0, 4'b0000, 1'b0, 1'b1, 4'd8},  // R8 owner reads
    {1'b1, 2'd0, 3'd0, 4'b0000, 1'b0, 1'b1, 4'd8},  // R8 owner writes
    {1'b1, 2'd3, 3'd5, 4'b0000, 1'b0, 1'b1, 4'd3},  // R3 write, uncached
    {1'b0, 2'd3, 3'd1, 4'b0000, 1'b0, 1'b0, 4'd2},  // R2 read, uncached
    {1'b1, 2'd3, 3'd1, 4'b0000, 1'b0, 1'b1, 4'd10}, // R10 sole sharer writes
    {1'b1, 2'd1, 3'd5, 4'b1000, 1'b0, 1'b1, 4'd7}   // R7 write, owner 3
  };

  task automatic chk(input int rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL R%0d: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic run_txn(input logic wr, input logic [1:0] nd, input logic [2:0] bk,
                         input logic [3:0] mk, input logic ft, input logic ex, input int rq);
    int nacks;
    nacks = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_node = nd; req_blk = bk;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (mk[i]) begin
        chk(rq, int'(msg_valid), 1);
        chk(rq, int'(msg_node), i);
        chk(rq, int'(msg_fetch), int'(ft));
        chk(rq, int'(msg_blk), int'(bk));
        chk(5, int'(rsp_valid), 0);
        nacks++;
        @(negedge clk);
      end
    end
    if (nacks > 0) begin
      chk(rq, int'(msg_valid), 0);
      for (int a = 0; a < nacks; a++) begin
        chk(5, int'(rsp_valid), 0);
        ack_valid = 1'b1;
        @(negedge clk);
        ack_valid = 1'b0;
      end
      chk(5, int'(rsp_valid), 0);
      @(negedge clk);
    end
    chk(rq, int'(rsp_valid), 1);
    chk(rq, int'(rsp_excl), int'(ex));
    chk(rq, int'(rsp_node), int'(nd));
    chk(rq, int'(rsp_blk), int'(bk));
    chk(rq, int'(msg_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 outputs idle after reset
    chk(1, int'(rsp_valid), 0);
    chk(1, int'(msg_valid), 0);
    chk(1, int'(rty_valid), 0);
    // R1 every block uncached: a write to block 7 needs no message
    run_txn(1'b1, 2'd2, 3'd7, 4'b0000, 1'b0, 1'b1, 1);

    for (int v = 0; v < 13; v++) begin
      run_txn(TBL[v][15], TBL[v][14:13], TBL[v][12:10], TBL[v][9:6],
              TBL[v][5], TBL[v][4], int'(TBL[v][3:0]));
    end

    // R9 request during an open transaction (block 0 owned by node 0)
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_node = 2'd2; req_blk = 3'd0;
    @(negedge clk);
    chk(9, int'(msg_valid), 1);
    chk(9, int'(msg_node), 0);
    req_write = 1'b0; req_node = 2'd3; req_blk = 3'd6;
    @(negedge clk);
    req_valid = 1'b0;
    chk(9, int'(rty_valid), 1);
    chk(9, int'(rty_node), 3);
    chk(9, int'(rty_blk), 6);
    chk(9, int'(msg_valid), 0);
    ack_valid = 1'b1;
    @(negedge clk);
    ack_valid = 1'b0;
    chk(9, int'(rty_valid), 0);
    @(negedge clk);
    chk(9, int'(rsp_valid), 1);
    chk(9, int'(rsp_excl), 1);
    chk(9, int'(rsp_node), 2);
    // R9 request in the grant cycle is refused as well
    req_valid = 1'b1; req_write = 1'b1; req_node = 2'd1; req_blk = 3'd3;
    @(negedge clk);
    req_valid = 1'b0;
    chk(9, int'(rty_valid), 1);
    chk(9, int'(rty_node), 1);
    chk(9, int'(rsp_valid), 0);
    // R9 refused read left block 6 uncached: write needs no invalidate
    run_txn(1'b1, 2'd1, 3'd6, 4'b0000, 1'b0, 1'b1, 9);
    // R9 refused write left block 3 uncached
    run_txn(1'b0, 2'd0, 3'd3, 4'b0000, 1'b0, 1'b0, 9);

    @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule